// File: doc/BRIEF.md
# Transposable Flit Buffer

This block stores one group of flits, each a data word plus one parity bit, in flip-flops. The group is a fixed number of data flits followed by one parity flit. The buffer works as an ordinary first-in first-out queue. It can also be reached in two other directions without moving its pointers. A column access reads or overwrites one whole flit chosen by its position in the queue. A row access reads or overwrites one bit position across every stored flit at once.

A sender fills the buffer with a complete group before releasing it. When the far end asks for a bit-column to be sent again, the sender reads that column in one cycle. The returned word holds bit k of each data flit, with bit k of the parity flit after them. A receiver uses a row write to patch a resent bit-column into the flits it already holds. It uses a column write to replace a single resent flit.

Flit positions are counted from the oldest stored flit. Index 0 is the head of the queue, and index FLITS is the last slot, which holds the parity flit of a full group. The depth is FLITS+1 entries.

Top module: `flit_xpose_buf`

## Requirements
- R1: Flits leave through pop_flit in the order they were pushed. While the buffer is not empty, pop_flit shows the oldest flit. A pop removes that flit at the clock edge.
- R2: After reset, count is 0 and empty is high. count always equals the number of stored flits, and never exceeds FLITS+1. empty is high exactly when count is 0, and full is high exactly when count is FLITS+1.
- R3: A push while full is ignored. A pop while empty is ignored. When the buffer is full, a push together with a pop performs only the pop.
- R4: col_rdata returns the whole flit at queue position col_idx, where position 0 is the oldest flit. It is valid in the same cycle as col_idx.
- R5: When col_we is high, the flit at queue position col_idx is replaced by col_wdata at the clock edge.
- R6: row_rdata bit i equals bit row_idx of the flit at queue position i. When the group is full, bit FLITS is therefore the parity flit's bit and follows the data flits' bits.
- R7: When row_we is high, bit row_idx of the flit at each queue position i is replaced by row_wdata bit i at the clock edge.
- R8: If col_we and row_we are both high in one cycle, access_clash is high in that cycle and neither write takes effect.
- R9: Column and row reads and writes never change count, full, empty or which flit is at the head.
- R10: If col_idx is FLITS+1 or more, col_rdata is zero and a column write does nothing. If row_idx is DATA_W+1 or more, row_rdata is zero and a row write does nothing.
- R11: If a push and a column write both target the slot being filled in the same cycle, the column write wins. A row write in the same cycle as a push also applies its bit to the pushed flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| push | input | 1 | Append push_flit at the tail |
| push_flit | input | DATA_W+1 | Flit to append |
| pop | input | 1 | Remove the head flit |
| pop_flit | output | DATA_W+1 | Head flit, valid while not empty |
| full | output | 1 | All FLITS+1 slots are occupied |
| empty | output | 1 | No flit is stored |
| count | output | $clog2(FLITS+2) | Number of stored flits |
| col_we | input | 1 | Column write strobe |
| col_idx | input | $clog2(FLITS+1) | Queue position for column access |
| col_wdata | input | DATA_W+1 | Flit for column write |
| col_rdata | output | DATA_W+1 | Flit at col_idx |
| row_we | input | 1 | Row write strobe |
| row_idx | input | $clog2(DATA_W+1) | Bit position for row access |
| row_wdata | input | FLITS+1 | One bit per queue position for row write |
| row_rdata | output | FLITS+1 | Bit row_idx of each queue position |
| access_clash | output | 1 | Column and row writes requested together |

## Verification
The bench first drives the head pointer around the ring, so that queue positions no longer match physical slots. A design that indexed random accesses by physical slot would then return or patch the wrong flit. It reads and writes every bit row of a full group, including the parity bit. A mis-rotated row port would show up as a bit appearing under the wrong flit or out of order.

The bench also targets these cases:
- Colliding row and column writes, where an unguarded design would corrupt storage.
- Indices beyond the group, where an unmasked design would alias onto real flits.
- A push while full, and a pop while empty, which would corrupt the count if accepted.
- A column write landing on the slot being pushed in the same cycle, where the wrong priority would keep the pushed value.

// File: rtl/tfb_pkg.sv
// Shared helpers for the transposable flit buffer.
// Assumes every ring position handed in is already below the depth.
package tfb_pkg;

    // Position offs steps after base on a ring of the given depth.
    function automatic int unsigned ring_slot(input int unsigned base,
                                              input int unsigned offs,
                                              input int unsigned depth);
        int unsigned s;
        s = base + offs;
        if (s >= depth) s = s - depth;
        return s;
    endfunction

    // Distance from base forward to slot on a ring of the given depth.
    function automatic int unsigned ring_dist(input int unsigned base,
                                              input int unsigned slot,
                                              input int unsigned depth);
        return (slot >= base) ? slot - base : slot + depth - base;
    endfunction

endpackage

// File: rtl/tfb_ptr_ctrl.sv
// Queue pointer and occupancy control.
// Accepts a push only when not full and a pop only when not empty.
// Random accesses never reach this module, so they cannot move the pointers.
module tfb_ptr_ctrl #(
    parameter int DEPTH = 5,
    parameter int IW    = 3,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic [IW-1:0] rd_ptr,
    output logic [IW-1:0] wr_ptr,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          push_fire,
    output logic          pop_fire
);
    localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

    // Qualify requests against the current occupancy.
    always_comb begin
        full      = (count == CW'(DEPTH));
        empty     = (count == '0);
        push_fire = push && !full;
        pop_fire  = pop && !empty;
    end

    // Advance the pointers and track the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_fire) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + IW'(1);
            if (pop_fire)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + IW'(1);
            count <= count + CW'(push_fire) - CW'(pop_fire);
        end
    end
endmodule

// File: rtl/tfb_cell_array.sv
// Flip-flop storage for DEPTH flits of W bits each.
// The caller makes row and column writes mutually exclusive.
// Priority for a shared cell: column write, then row bit, then push.
module tfb_cell_array #(
    parameter int DEPTH = 5,
    parameter int W     = 9,
    parameter int IW    = 3,
    parameter int BW    = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push_en,
    input  logic [IW-1:0]             push_slot,
    input  logic [W-1:0]              push_data,
    input  logic                      col_en,
    input  logic [IW-1:0]             col_slot,
    input  logic [W-1:0]              col_data,
    input  logic                      row_en,
    input  logic [BW-1:0]             row_bit,
    input  logic [DEPTH-1:0]          row_phys,
    output logic [DEPTH-1:0][W-1:0]   cells
);
    logic [DEPTH-1:0][W-1:0] nxt;

    // Merge push, row and column updates into the next contents.
    always_comb begin
        nxt = cells;
        for (int s = 0; s < DEPTH; s++) begin
            if (push_en && push_slot == IW'(s)) nxt[s] = push_data;
            if (row_en) begin
                for (int b = 0; b < W; b++) begin
                    if (row_bit == BW'(b)) nxt[s][b] = row_phys[s];
                end
            end
            if (col_en && col_slot == IW'(s)) nxt[s] = col_data;
        end
    end

    // Register the storage.
    always_ff @(posedge clk) begin
        if (!rst_n) cells <= '0;
        else        cells <= nxt;
    end
endmodule

// File: rtl/tfb_row_gather.sv
// Row port steering between queue order and physical slots.
// Queue position i lives in slot (rd_ptr + i) mod DEPTH.
module tfb_row_gather #(
    parameter int DEPTH = 5,
    parameter int W     = 9,
    parameter int IW    = 3,
    parameter int BW    = 4
) (
    input  logic [IW-1:0]           rd_ptr,
    input  logic [BW-1:0]           row_bit,
    input  logic [DEPTH-1:0][W-1:0] cells,
    input  logic [DEPTH-1:0]        row_wdata,
    output logic [DEPTH-1:0]        row_word,
    output logic [DEPTH-1:0]        row_phys
);
    import tfb_pkg::*;

    for (genvar i = 0; i < DEPTH; i++) begin : g_lane
        logic [IW-1:0] src_slot;
        logic [IW-1:0] rel_pos;
        logic [W-1:0]  flit;

        // Gather one bit of queue position i, and scatter one write bit into slot i.
        always_comb begin
            src_slot    = IW'(ring_slot(int'(rd_ptr), i, DEPTH));
            rel_pos     = IW'(ring_dist(int'(rd_ptr), i, DEPTH));
            flit        = cells[src_slot];
            row_word[i] = 1'b0;
            for (int b = 0; b < W; b++) begin
                if (row_bit == BW'(b)) row_word[i] = flit[b];
            end
            row_phys[i] = row_wdata[rel_pos];
        end
    end
endmodule

// File: rtl/flit_xpose_buf.sv
// Transposable flit buffer top level.
// Provides FIFO access plus access by flit position and by bit position.
// Holds FLITS data flits and one parity flit, each DATA_W+1 bits wide.
// Random indices are relative to the oldest stored flit.
module flit_xpose_buf #(
    parameter int FLITS  = 4,
    parameter int DATA_W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              push,
    input  logic [DATA_W:0]                   push_flit,
    input  logic                              pop,
    output logic [DATA_W:0]                   pop_flit,
    output logic                              full,
    output logic                              empty,
    output logic [$clog2(FLITS+2)-1:0]        count,
    input  logic                              col_we,
    input  logic [$clog2(FLITS+1)-1:0]        col_idx,
    input  logic [DATA_W:0]                   col_wdata,
    output logic [DATA_W:0]                   col_rdata,
    input  logic                              row_we,
    input  logic [$clog2(DATA_W+1)-1:0]       row_idx,
    input  logic [FLITS:0]                    row_wdata,
    output logic [FLITS:0]                    row_rdata,
    output logic                              access_clash
);
    import tfb_pkg::*;

    localparam int DEPTH = FLITS + 1;
    localparam int W     = DATA_W + 1;
    localparam int IW    = $clog2(DEPTH);
    localparam int BW    = $clog2(W);
    localparam int CW    = $clog2(DEPTH + 1);

    logic [IW-1:0]           rd_ptr, wr_ptr, col_slot;
    logic                    push_fire, pop_fire;
    logic                    col_ok, row_ok, col_en, row_en;
    logic [DEPTH-1:0][W-1:0] cells;
    logic [DEPTH-1:0]        row_word, row_phys;

    tfb_ptr_ctrl #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .count(count),
        .full(full), .empty(empty),
        .push_fire(push_fire), .pop_fire(pop_fire)
    );

    // Decode index ranges, the write clash and the column slot.
    always_comb begin
        col_ok       = ({1'b0, col_idx} < (IW+1)'(DEPTH));
        row_ok       = ({1'b0, row_idx} < (BW+1)'(W));
        access_clash = col_we && row_we;
        col_en       = col_we && !row_we && col_ok;
        row_en       = row_we && !col_we && row_ok;
        col_slot     = IW'(ring_slot(int'(rd_ptr), int'(col_idx), DEPTH));
    end

    tfb_cell_array #(.DEPTH(DEPTH), .W(W), .IW(IW), .BW(BW)) u_cells (
        .clk(clk), .rst_n(rst_n),
        .push_en(push_fire), .push_slot(wr_ptr), .push_data(push_flit),
        .col_en(col_en), .col_slot(col_slot), .col_data(col_wdata),
        .row_en(row_en), .row_bit(row_idx), .row_phys(row_phys),
        .cells(cells)
    );

    tfb_row_gather #(.DEPTH(DEPTH), .W(W), .IW(IW), .BW(BW)) u_rows (
        .rd_ptr(rd_ptr), .row_bit(row_idx), .cells(cells),
        .row_wdata(row_wdata), .row_word(row_word), .row_phys(row_phys)
    );

    // Drive the read ports, masking any index outside the group.
    always_comb begin
        pop_flit  = cells[rd_ptr];
        col_rdata = col_ok ? cells[col_slot] : '0;
        row_rdata = row_ok ? row_word : '0;
    end
endmodule

// File: rtl/flit_xpose_buf_chk.sv
// Property checker for flit_xpose_buf, attached with bind.
// Checks occupancy, ignored requests and the effect-free clash case.
module flit_xpose_buf_chk #(
    parameter int FLITS  = 4,
    parameter int DATA_W = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       push,
    input logic                       pop,
    input logic                       col_we,
    input logic                       row_we,
    input logic [DATA_W:0]            pop_flit,
    input logic                       full,
    input logic                       empty,
    input logic [$clog2(FLITS+2)-1:0] count
);
    localparam int CW = $clog2(FLITS + 2);

    assert_flags_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(FLITS + 1));
    assert_push_grows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!full && push && !pop) |=> count == $past(count) + CW'(1));
    assert_full_push_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && count == $past(count)));
    assert_empty_pop_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);
    assert_random_keeps_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((col_we || row_we) && !push && !pop) |=> count == $past(count));
    assert_clash_no_effect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (col_we && row_we && !push && !pop && !empty) |=> $stable(pop_flit));
endmodule

bind flit_xpose_buf flit_xpose_buf_chk #(.FLITS(FLITS), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .col_we(col_we), .row_we(row_we), .pop_flit(pop_flit),
    .full(full), .empty(empty), .count(count)
);

// File: tb/sim_flit_xpose_buf.sv
// Self-checking bench with a queue-based reference model compared every cycle.
module sim_flit_xpose_buf;
    localparam int M  = 4;
    localparam int N  = 8;
    localparam int D  = M + 1;
    localparam int W  = N + 1;
    localparam int IW = $clog2(D);
    localparam int BW = $clog2(W);
    localparam int CW = $clog2(D + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push = 0, pop = 0, col_we = 0, row_we = 0;
    logic [W-1:0] push_flit = '0, col_wdata = '0;
    logic [IW-1:0] col_idx = '0;
    logic [BW-1:0] row_idx = '0;
    logic [D-1:0] row_wdata = '0;
    logic [W-1:0] pop_flit, col_rdata;
    logic [D-1:0] row_rdata;
    logic full, empty, access_clash;
    logic [CW-1:0] count;

    int checks = 0;
    int fails = 0;
    logic [W-1:0] q[$];

    always #2 clk = ~clk;

    flit_xpose_buf #(.FLITS(M), .DATA_W(N)) u0 (
        .clk(clk), .rst_n(rst_n), .push(push), .push_flit(push_flit),
        .pop(pop), .pop_flit(pop_flit), .full(full), .empty(empty), .count(count),
        .col_we(col_we), .col_idx(col_idx), .col_wdata(col_wdata), .col_rdata(col_rdata),
        .row_we(row_we), .row_idx(row_idx), .row_wdata(row_wdata), .row_rdata(row_rdata),
        .access_clash(access_clash)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, compare, then advance the model.
    task automatic step(input bit p, input logic [W-1:0] pd, input bit pp,
                        input bit cw, input int ci, input logic [W-1:0] cd,
                        input bit rw, input int ri, input logic [D-1:0] rwd);
        logic [D-1:0] exp_row, mask;
        logic [W-1:0] f;
        @(negedge clk);
        push = p; push_flit = pd; pop = pp;
        col_we = cw; col_idx = IW'(ci); col_wdata = cd;
        row_we = rw; row_idx = BW'(ri); row_wdata = rwd;
        #1;
        chk(count == CW'(q.size()), "R2 count", 32'(count), 32'(q.size()));
        chk(empty == (q.size() == 0), "R2 empty", 32'(empty), 32'(q.size() == 0));
        chk(full == (q.size() == D), "R2 full", 32'(full), 32'(q.size() == D));
        chk(access_clash == (cw && rw), "R8 clash flag", 32'(access_clash), 32'(cw && rw));
        if (q.size() > 0) chk(pop_flit == q[0], "R1 head", 32'(pop_flit), 32'(q[0]));
        if (ci >= D) chk(col_rdata == '0, "R10 col range", 32'(col_rdata), 0);
        else if (ci < q.size()) chk(col_rdata == q[ci], "R4 col read", 32'(col_rdata), 32'(q[ci]));
        if (ri >= W) chk(row_rdata == '0, "R10 row range", 32'(row_rdata), 0);
        else begin
            exp_row = '0; mask = '0;
            for (int i = 0; i < q.size(); i++) begin
                f = q[i];
                exp_row[i] = f[ri];
                mask[i] = 1'b1;
            end
            chk((row_rdata & mask) == exp_row, "R6 row read", 32'(row_rdata & mask), 32'(exp_row));
        end
        // Model update: push, then writes by queue position, then pop (R3, R5, R7, R11).
        begin
            bit do_pop;
            do_pop = pp && q.size() > 0;
            if (p && q.size() < D) q.push_back(pd);
            if (!(cw && rw)) begin
                if (cw && ci < q.size()) q[ci] = cd;
                if (rw && ri < W) begin
                    for (int i = 0; i < q.size(); i++) begin
                        f = q[i]; f[ri] = rwd[i]; q[i] = f;
                    end
                end
            end
            if (do_pop) void'(q.pop_front());
        end
    endtask

    task automatic idle(input int ci, input int ri);
        step(0, '0, 0, 0, ci, '0, 0, ri, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        idle(0, 0);                                   // R2 reset state
        // Rotate the head away from slot 0 (R1).
        step(1, 9'h011, 0, 0, 0, '0, 0, 0, '0);
        step(1, 9'h022, 0, 0, 0, '0, 0, 0, '0);
        step(0, '0, 1, 0, 0, '0, 0, 0, '0);
        step(0, '0, 1, 0, 0, '0, 0, 0, '0);
        step(0, '0, 1, 0, 0, '0, 0, 0, '0);            // R3 pop on empty
        // Fill a full group, the last flit being parity.
        for (int i = 0; i < D; i++) step(1, W'(9'h0A5 ^ (i * 9'h037)), 0, 0, 0, '0, 0, 0, '0);
        step(1, 9'h1FF, 0, 0, 0, '0, 0, 0, '0);        // R3 push on full
        step(1, 9'h1EE, 1, 0, 0, '0, 0, 0, '0);        // R3 push+pop on full
        step(1, 9'h0C3, 0, 0, 0, '0, 0, 0, '0);
        for (int i = 0; i < 8; i++) idle(i, 0);        // R4, R10
        for (int b = 0; b < 16; b++) idle(0, b);       // R6, R10
        step(0, '0, 0, 1, 2, 9'h155, 0, 0, '0);        // R5, R9
        step(0, '0, 0, 0, 0, '0, 1, 3, 5'b10110);      // R7, R9
        step(0, '0, 0, 0, 0, '0, 1, 8, 5'b01011);      // R7 parity bit row
        step(0, '0, 0, 1, 1, 9'h0F0, 1, 4, 5'b11111);  // R8 clash
        step(0, '0, 0, 1, 6, 9'h0AA, 0, 0, '0);        // R10 col write out of range
        step(0, '0, 0, 0, 0, '0, 1, 12, 5'b11111);     // R10 row write out of range
        for (int b = 0; b < W; b++) idle(b % D, b);
        for (int i = 0; i < D; i++) step(0, '0, 1, 0, 0, '0, 0, 0, '0);
        step(1, 9'h101, 0, 1, 0, 9'h0BE, 0, 0, '0);    // R11 col write wins over push
        step(1, 9'h102, 0, 0, 0, '0, 1, 0, 5'b00011);  // R11 row bit on pushed flit
        idle(0, 0);
        idle(1, 0);
        for (int k = 0; k < 3000; k++) begin
            step($urandom % 2 == 0, W'($urandom), $urandom % 5 < 2,
                 $urandom % 6 == 0, int'($urandom % 8), W'($urandom),
                 $urandom % 6 == 0, int'($urandom % 16), D'($urandom));
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule